// File: doc/BRIEF.md
# Add-Only Page Memory Controller

This block is the memory-function layer of a one-time-programmable page memory. It sits behind a byte-level link to a bus master. The master sends command and address bytes, asks for reply bytes one at a time, and pulses a program strobe when a byte is to be burned. The storage is a register array. The data memory holds `PAGES` pages of `PAGE_BYTES` bytes. The default build is small; the full-size part is 256 pages of 32 bytes, 65536 bits. A separate status memory holds two things: one write-protect bit per data page, and one redirection byte per data page.

The memory is add-only. Programming performs `new = old AND written`, so a bit can go from 1 to 0 but never back. Software cannot erase a page, so it retires the page instead. It writes the number of a replacement page into the old page's redirection byte, and a reader follows that pointer. Each hop of such a chain is one more extended read. The extended read command helps with this. It streams each page to its end and then sends that page's redirection byte, followed by a CRC-16 over that byte alone. The master can therefore check every pointer it is about to follow.

Every write passes through a one-byte holding register. The block returns a CRC-16 over the command, the address and the byte before the master commits the write with a program pulse. It then returns the stored byte as a read-back.

Top module: `amem_addonly`

## Requirements
- R1: After `rst_n` is released, `out_valid` is 0. Every data and status byte reads FFh.
- R2: Every `out_req` pulse produces one `out_valid` pulse with `out_byte` in the following cycle. Command F0h, followed by the address low byte and then the high byte, streams data bytes upward from that address, one byte per request.
- R3: A read that runs past the last byte of its field, or that starts beyond it, returns FFh on every request until `bus_rst`.
- R4: Command AAh streams the status memory in the same way as R2. Byte `p/8` holds the protect bit of page `p` at bit `p%8`, and a value of 0 means the page is locked. The redirection byte of page `p` is at status address `PROT_BYTES+p`, where `PROT_BYTES = ceil(PAGES/8)`.
- R5: Command A5h (extended read) streams data from the start address to the end of its page. It then sends that page's redirection byte, then the inverted CRC-16 of that byte alone, low byte first, and then moves on to the next page. After the CRC of the last page, and for a start address beyond the data field, it returns FFh.
- R6: Command 0Fh (write data) takes one data byte and returns two CRC bytes. The CRC uses the polynomial x^16+x^15+x^2+1, is processed LSB first from a cleared register, and is sent inverted, low byte first. For the first byte it covers the command, the address low byte, the address high byte and the data byte. For each later byte it covers the incremented address low byte, high byte and data byte.
- R7: A `prog_pulse` sent after both CRC bytes sets the stored byte to `old AND data`. The next request returns the stored byte, and the address then advances by one for the next data byte.
- R8: A write to a page whose protect bit is 0 leaves the data unchanged. The read-back returns the old byte.
- R9: Command 55h (write status) follows R6 and R7 on the status memory. It is not subject to page protection.
- R10: `bus_rst` returns the block to waiting for a command from any state, and aborts an uncommitted write. An unknown command byte makes the block return FFh until `bus_rst`.
- R11: A `prog_pulse` at any time other than after both CRC bytes of a pending write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all memory returns to erased (FFh) |
| bus_rst | input | 1 | Link reset pulse; aborts the current command |
| in_valid | input | 1 | A byte from the master is present on `in_byte` |
| in_byte | input | 8 | Byte from the master |
| out_req | input | 1 | Master asks for the next reply byte |
| out_valid | output | 1 | Reply byte present, one cycle after `out_req` |
| out_byte | output | 8 | Reply byte |
| prog_pulse | input | 1 | Commit the pending write |

## Verification
The bench builds the block with `PAGES=4` and `PAGE_BYTES=4`. This gives 16 data bytes and 5 status bytes, a single protect byte, and page boundaries every fourth address. At this size every data and status address can be written, read back and streamed in full. The extended read crosses every page boundary and reaches the end-of-field fill, and a locked page sits between two unlocked ones. All CRC values and the AND-merged memory image are recomputed in the bench by bit arithmetic.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam logic [7:0] CMD_RD   = 8'hF0;
  localparam logic [7:0] CMD_RDS  = 8'hAA;
  localparam logic [7:0] CMD_RDX  = 8'hA5;
  localparam logic [7:0] CMD_WR   = 8'h0F;
  localparam logic [7:0] CMD_WRS  = 8'h55;

  typedef enum logic [3:0] {
    S_CMD, S_ADRL, S_ADRH, S_IGN,
    S_RD,
    S_XDAT, S_XRB, S_XCL, S_XCH, S_XEND,
    S_WDAT, S_WCL, S_WCH, S_WPROG, S_WVFY
  } amem_st_t;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_RD) || (c == CMD_RDS) || (c == CMD_RDX) ||
           (c == CMD_WR) || (c == CMD_WRS);
  endfunction

  // One byte through the reflected x^16+x^15+x^2+1 generator, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/amem_store.sv
module amem_store #(
  parameter int DEPTH = 16,
  parameter int NRD   = 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [7:0]               wmask,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][7:0]      rdata
);

  logic [7:0] cells [DEPTH];

  // Erased state is all ones; a write can only clear bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) begin
      cells[waddr] <= cells[waddr] & wmask;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = ({1'b0, raddr[g]} < (AW+1)'(DEPTH)) ? cells[raddr[g]] : 8'hFF;
  end

endmodule

// File: rtl/amem_crc16.sv
module amem_crc16
  import amem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        sh_a,
  input  logic [7:0]  d_a,
  input  logic        sh_b,
  input  logic [7:0]  d_b,
  output logic [15:0] crc
);

  logic [15:0] base, mid, nxt;

  always_comb begin
    base = clr  ? 16'h0000 : crc;
    mid  = sh_a ? crc16_step(base, d_a) : base;
    nxt  = sh_b ? crc16_step(mid, d_b) : mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crc <= 16'h0000;
    else        crc <= nxt;
  end

endmodule

// File: rtl/amem_addonly.sv
module amem_addonly
  import amem_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       out_req,
  output logic       out_valid,
  output logic [7:0] out_byte,
  input  logic       prog_pulse
);

  localparam int DATA_BYTES = PAGES * PAGE_BYTES;
  localparam int PROT_BYTES = (PAGES + 7) / 8;
  localparam int STAT_BYTES = PROT_BYTES + PAGES;
  localparam int DAW        = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int SAW        = (STAT_BYTES > 1) ? $clog2(STAT_BYTES) : 1;
  localparam int PBW        = $clog2(PAGE_BYTES);

  amem_st_t    st;
  logic [7:0]  cmd;
  logic [15:0] addr;
  logic [7:0]  wdat;
  logic [15:0] crc;

  // Named internal events, also used by the checker.
  logic data_we, stat_we, page_locked, at_cmd, field_end;

  logic [15:0] page16, addr_n;
  logic        data_in_rng, stat_in_rng, last_in_page, ext_mode, prot_clear;
  logic [DAW-1:0]          d_waddr;
  logic [0:0][DAW-1:0]     d_raddr;
  logic [0:0][7:0]         d_rdata;
  logic [SAW-1:0]          s_waddr;
  logic [1:0][SAW-1:0]     s_raddr;
  logic [1:0][7:0]         s_rdata;
  logic [7:0]  d_byte, s_byte, nxt_out;
  logic        crc_clr, crc_sa, crc_sb;
  logic [7:0]  crc_da, crc_db;

  assign page16       = addr >> PBW;
  assign addr_n       = addr + 16'd1;
  assign data_in_rng  = {1'b0, addr} < 17'(DATA_BYTES);
  assign stat_in_rng  = {1'b0, addr} < 17'(STAT_BYTES);
  assign last_in_page = addr[PBW-1:0] == PBW'(PAGE_BYTES - 1);
  assign ext_mode     = (st == S_XDAT) || (st == S_XRB) || (st == S_XCL) || (st == S_XCH);

  // Storage
  assign d_waddr    = DAW'(addr);
  assign d_raddr[0] = DAW'(addr);
  assign s_waddr    = SAW'(addr);
  assign s_raddr[0] = ext_mode ? SAW'(16'(PROT_BYTES) + page16) : SAW'(addr);
  assign s_raddr[1] = SAW'(page16 >> 3);

  amem_store #(.DEPTH(DATA_BYTES), .NRD(1)) u_data (
    .clk(clk), .rst_n(rst_n), .we(data_we), .waddr(d_waddr), .wmask(wdat),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  amem_store #(.DEPTH(STAT_BYTES), .NRD(2)) u_stat (
    .clk(clk), .rst_n(rst_n), .we(stat_we), .waddr(s_waddr), .wmask(wdat),
    .raddr(s_raddr), .rdata(s_rdata)
  );

  assign d_byte     = data_in_rng ? d_rdata[0] : 8'hFF;
  assign s_byte     = stat_in_rng ? s_rdata[0] : 8'hFF;
  assign prot_clear = ~s_rdata[1][page16[2:0]];

  // Write events
  assign page_locked = (cmd == CMD_WR) && data_in_rng && prot_clear;
  assign data_we = (st == S_WPROG) && prog_pulse && !bus_rst && (cmd == CMD_WR) &&
                   data_in_rng && !prot_clear;
  assign stat_we = (st == S_WPROG) && prog_pulse && !bus_rst && (cmd == CMD_WRS) &&
                   stat_in_rng;

  assign at_cmd    = (st == S_CMD);
  assign field_end = (st == S_XEND) ||
                     ((st == S_RD) && !((cmd == CMD_RDS) ? stat_in_rng : data_in_rng));

  // CRC control
  always_comb begin
    crc_clr = 1'b0; crc_sa = 1'b0; crc_sb = 1'b0;
    crc_da  = in_byte; crc_db = 8'h00;
    unique case (st)
      S_CMD:          if (in_valid) begin crc_clr = 1'b1; crc_sa = 1'b1; end
      S_ADRL, S_ADRH,
      S_WDAT:         crc_sa = in_valid;
      S_WVFY: if (out_req) begin
        crc_clr = 1'b1; crc_sa = 1'b1; crc_sb = 1'b1;
        crc_da  = addr_n[7:0]; crc_db = addr_n[15:8];
      end
      S_XRB: if (out_req) begin
        crc_clr = 1'b1; crc_sa = 1'b1; crc_da = s_rdata[0];
      end
      default: ;
    endcase
  end

  amem_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .sh_a(crc_sa), .d_a(crc_da),
    .sh_b(crc_sb), .d_b(crc_db), .crc(crc)
  );

  // Reply byte selection
  always_comb begin
    unique case (st)
      S_RD:         nxt_out = (cmd == CMD_RDS) ? s_byte : d_byte;
      S_XDAT:       nxt_out = d_byte;
      S_XRB:        nxt_out = s_rdata[0];
      S_XCL, S_WCL: nxt_out = ~crc[7:0];
      S_XCH, S_WCH: nxt_out = ~crc[15:8];
      S_WVFY:       nxt_out = (cmd == CMD_WR) ? d_byte : s_byte;
      default:      nxt_out = 8'hFF;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CMD;
      cmd       <= 8'h00;
      addr      <= 16'h0000;
      wdat      <= 8'hFF;
      out_valid <= 1'b0;
      out_byte  <= 8'hFF;
    end else begin
      out_valid <= out_req;
      if (out_req) out_byte <= nxt_out;
      if (bus_rst) begin
        st <= S_CMD;
      end else begin
        unique case (st)
          S_CMD: if (in_valid) begin
            cmd <= in_byte;
            st  <= cmd_known(in_byte) ? S_ADRL : S_IGN;
          end
          S_ADRL: if (in_valid) begin
            addr[7:0] <= in_byte;
            st        <= S_ADRH;
          end
          S_ADRH: if (in_valid) begin
            addr[15:8] <= in_byte;
            if (cmd == CMD_RD || cmd == CMD_RDS)      st <= S_RD;
            else if (cmd == CMD_RDX)
              st <= ({1'b0, in_byte, addr[7:0]} < 17'(DATA_BYTES)) ? S_XDAT : S_XEND;
            else                                      st <= S_WDAT;
          end
          S_RD: if (out_req && ((cmd == CMD_RDS) ? stat_in_rng : data_in_rng))
            addr <= addr_n;
          S_XDAT: if (out_req) begin
            if (last_in_page) st <= S_XRB;
            else              addr <= addr_n;
          end
          S_XRB: if (out_req) st <= S_XCL;
          S_XCL: if (out_req) st <= S_XCH;
          S_XCH: if (out_req) begin
            if (page16 == 16'(PAGES - 1)) st <= S_XEND;
            else begin
              addr <= addr_n;
              st   <= S_XDAT;
            end
          end
          S_WDAT: if (in_valid) begin
            wdat <= in_byte;
            st   <= S_WCL;
          end
          S_WCL:   if (out_req)    st <= S_WCH;
          S_WCH:   if (out_req)    st <= S_WPROG;
          S_WPROG: if (prog_pulse) st <= S_WVFY;
          S_WVFY: if (out_req) begin
            addr <= addr_n;
            st   <= S_WDAT;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/amem_addonly_chk.sv
module amem_addonly_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       out_req,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       prog_pulse,
  input logic       data_we,
  input logic       stat_we,
  input logic       page_locked,
  input logic       at_cmd,
  input logic       field_end
);

  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_req));

  a_r2_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);

  a_r3_ff_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && out_req && !bus_rst) |=> (out_byte == 8'hFF));

  a_r8_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    page_locked |-> !data_we);

  a_r11_write_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we || stat_we) |-> prog_pulse);

  a_r10_busrst_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> at_cmd);

endmodule

bind amem_addonly amem_addonly_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .out_req(out_req),
  .out_valid(out_valid), .out_byte(out_byte), .prog_pulse(prog_pulse),
  .data_we(data_we), .stat_we(stat_we), .page_locked(page_locked),
  .at_cmd(at_cmd), .field_end(field_end)
);

// File: tb/amem_addonly_test.sv
module amem_addonly_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PB = 4;
  localparam int ND = NP * PB;
  localparam int NPROT = 1;
  localparam int NS = NPROT + NP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_req = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       prog_pulse = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] mdata [ND];
  logic [7:0] mstat [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  amem_addonly #(.PAGES(NP), .PAGE_BYTES(PB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .in_valid(in_valid),
    .in_byte(in_byte), .out_req(out_req), .out_valid(out_valid),
    .out_byte(out_byte), .prog_pulse(prog_pulse)
  );

  // CRC restated as a shift of the reflected register with feedback taps.
  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {fb, r[15:1]} ^ {2'b00, fb, 12'h000, fb};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk); out_req = 1'b1;
    @(negedge clk); out_req = 1'b0;
    check(out_valid === 1'b1, "R2 valid", {15'd0, out_valid}, 16'd1);
    b = out_byte;
  endtask

  task automatic pulse_prog();
    @(negedge clk); prog_pulse = 1'b1;
    @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic link_reset();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic start(input logic [7:0] c, input logic [15:0] a);
    send(c); send(a[7:0]); send(a[15:8]);
  endtask

  // One write step: data byte, CRC pair, program, read-back.
  task automatic wr_step(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d,
                         input bit first, input bit stat, input string tag);
    logic [15:0] cr;
    logic [7:0]  b, exp;
    int pg;
    cr = first ? crc_b(crc_b(crc_b(crc_b(16'h0, c), a[7:0]), a[15:8]), d)
               : crc_b(crc_b(crc_b(16'h0, a[7:0]), a[15:8]), d);
    send(d);
    get(b); check(b == ~cr[7:0],  "R6 crc low",  {8'd0, b}, {8'd0, ~cr[7:0]});
    get(b); check(b == ~cr[15:8], "R6 crc high", {8'd0, b}, {8'd0, ~cr[15:8]});
    pulse_prog();
    if (stat) begin
      mstat[a] = mstat[a] & d;
      exp = mstat[a];
    end else begin
      pg = int'(a) / PB;
      if (mstat[pg / 8][pg % 8]) mdata[a] = mdata[a] & d;
      exp = mdata[a];
    end
    get(b); check(b == exp, tag, {8'd0, b}, {8'd0, exp});
  endtask

  task automatic rd_stream(input logic [7:0] c, input logic [15:0] a, input int extra, input string tag);
    logic [7:0] b, exp;
    int lim;
    lim = (c == 8'hAA) ? NS : ND;
    start(c, a);
    for (int i = int'(a); i < lim + extra; i++) begin
      exp = (i < lim) ? ((c == 8'hAA) ? mstat[i] : mdata[i]) : 8'hFF;
      get(b);
      check(b == exp, (i < lim) ? tag : "R3 past end", {8'd0, b}, {8'd0, exp});
    end
    link_reset();
  endtask

  task automatic ext_stream(input logic [15:0] a);
    logic [7:0]  b, rb;
    logic [15:0] cr;
    int i;
    start(8'hA5, a);
    i = int'(a);
    for (int pg = i / PB; pg < NP; pg++) begin
      for (; i < (pg + 1) * PB; i++) begin
        get(b); check(b == mdata[i], "R5 data", {8'd0, b}, {8'd0, mdata[i]});
      end
      rb = mstat[NPROT + pg];
      cr = ~crc_b(16'h0, rb);
      get(b); check(b == rb,        "R5 redirect", {8'd0, b}, {8'd0, rb});
      get(b); check(b == cr[7:0],   "R5 crc low",  {8'd0, b}, {8'd0, cr[7:0]});
      get(b); check(b == cr[15:8],  "R5 crc high", {8'd0, b}, {8'd0, cr[15:8]});
    end
    for (int k = 0; k < 2; k++) begin
      get(b); check(b == 8'hFF, "R5 ones after last page", {8'd0, b}, 16'h00FF);
    end
    link_reset();
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    for (int i = 0; i < ND; i++) mdata[i] = 8'hFF;
    for (int i = 0; i < NS; i++) mstat[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid idle", {15'd0, out_valid}, 16'd0);

    // R1: erased contents, R2/R3 streaming and fill
    rd_stream(8'hF0, 16'h0000, 3, "R1 erased data");
    rd_stream(8'hAA, 16'h0000, 2, "R1 erased status");

    // R6/R7: sweep every data address in one command
    send(8'h0F); send(8'h00); send(8'h00);
    for (int a = 0; a < ND; a++)
      wr_step(8'h0F, 16'(a), 8'((a * 37 + 5) & 8'hFF), a == 0, 1'b0, "R7 readback");
    link_reset();

    // R7: second pass, AND-merge keeps cleared bits cleared
    start(8'h0F, 16'h0004);
    for (int a = 4; a < 8; a++)
      wr_step(8'h0F, 16'(a), 8'hF0 ^ 8'(a), a == 4, 1'b0, "R7 and-only");
    link_reset();

    // R9: lock page 2, write page 0 redirection; then page 2 redirection
    start(8'h55, 16'h0000);
    wr_step(8'h55, 16'h0000, 8'hFB, 1'b1, 1'b1, "R9 protect byte");
    wr_step(8'h55, 16'h0001, 8'hFC, 1'b0, 1'b1, "R9 redirect page0");
    link_reset();
    start(8'h55, 16'h0003);
    wr_step(8'h55, 16'h0003, 8'h5A, 1'b1, 1'b1, "R9 redirect page2");
    link_reset();

    // R8: locked page 2 keeps data; page 3 still writable
    start(8'h0F, 16'h0008);
    wr_step(8'h0F, 16'h0008, 8'h00, 1'b1, 1'b0, "R8 locked readback");
    wr_step(8'h0F, 16'h0009, 8'h00, 1'b0, 1'b0, "R8 locked readback");
    link_reset();
    start(8'h0F, 16'h000C);
    wr_step(8'h0F, 16'h000C, 8'h0F, 1'b1, 1'b0, "R8 unlocked neighbour");
    link_reset();

    // R2/R3/R4: reads from mid-field and of status
    rd_stream(8'hF0, 16'h0005, 3, "R2 data stream");
    rd_stream(8'hAA, 16'h0000, 2, "R4 status stream");
    rd_stream(8'hAA, 16'h0002, 1, "R4 status mid");

    // R3: start beyond the field
    start(8'hF0, 16'h0100);
    get(b); check(b == 8'hFF, "R3 start beyond", {8'd0, b}, 16'h00FF);
    link_reset();

    // R5: extended read from page start and from mid-page, and beyond the field
    ext_stream(16'h0000);
    ext_stream(16'h0006);
    start(8'hA5, 16'h0040);
    get(b); check(b == 8'hFF, "R5 start beyond", {8'd0, b}, 16'h00FF);
    link_reset();

    // R10: abort an uncommitted write; the stray pulse afterwards is R11
    start(8'h0F, 16'h000D);
    send(8'h00);
    get(b); get(b);
    link_reset();
    pulse_prog();
    start(8'hF0, 16'h000D);
    get(b); check(b == mdata[13], "R10 aborted write", {8'd0, b}, {8'd0, mdata[13]});
    link_reset();

    // R11: pulse before the CRC bytes are read has no effect
    start(8'h0F, 16'h000E);
    send(8'h00);
    pulse_prog();
    link_reset();
    start(8'hF0, 16'h000E);
    get(b); check(b == mdata[14], "R11 early pulse", {8'd0, b}, {8'd0, mdata[14]});
    link_reset();

    // R10: unknown command answers ones until link reset, then commands work again
    send(8'h33);
    send(8'h00);
    get(b); check(b == 8'hFF, "R10 unknown command", {8'd0, b}, 16'h00FF);
    link_reset();
    start(8'hF0, 16'h0000);
    get(b); check(b == mdata[0], "R10 command after reset", {8'd0, b}, {8'd0, mdata[0]});
    link_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule